// File: doc/BRIEF.md
# Per-Core Interval Tick Timer Array

This block holds a parameterised array of identical local timer channels, one per processor core. Each channel owns its own interrupt line. Software reaches the channels through a simple register port. Channel n occupies a 256-byte window that starts at 0x300 + 0x100*n, and the low eight address bits pick a register inside that window.

Each channel counts in two stages. The first stage is a tick down-counter that runs once per clock while the channel is started. Each time it passes through zero, it reloads from its tick buffer and emits one tick. The second stage is an interrupt down-counter that spends those ticks. Once it has used up its buffered count, the channel marks an interrupt as pending. In interval mode the second stage then reloads and keeps running. Otherwise the channel drops its interrupt-generation bit and raises no further interrupts.

Every write to a buffer or to the control register is acknowledged by a sticky bit in a write-status register, which software clears by writing 1. Requests addressed outside the channel windows are ignored.

Top module: `core_tick_array`

## Requirements
- R1: Channel n (0 <= n < NUM_CORES) responds at addresses 0x300 + 0x100*n through 0x3FF + 0x100*n, and bits [7:0] select the register. A write outside every window changes no channel, and a read outside every window returns 0.
- R2: The registers sit at these offsets: tick buffer at 0x00, interrupt-count buffer at 0x08, control at 0x20, interrupt status at 0x30 (bit 0), interrupt enable at 0x34 (bit 0), write status at 0x40. Read data is valid in the cycle after the read request. An unmapped offset reads 0.
- R3: Writing the tick buffer also loads the tick counter. While control bit 0 (run) is 1, the counter decrements on every clock, and at zero it reloads from the buffer and emits one tick. A tick therefore occurs every TB+1 cycles.
- R4: Writing the interrupt-count buffer also loads the interrupt counter, which is consumed only on ticks while control bit 1 (generate) is 1. Suppose buffers TB and IB are written and control is then written with run and generate set at clock edge E. The interrupt output then rises exactly (TB+1)*(IB+1)+1 edges after E.
- R5: With control bit 2 (interval) set, the interrupt counter reloads on expiry and control keeps the value 7. After the pending status is cleared, another interrupt follows.
- R6: With bit 2 clear, the channel clears control bit 1 on expiry and raises no further pending status.
- R7: Interrupt status bit 0 is set on expiry and cleared by writing 1 to it.
- R8: The interrupt output is the registered AND of the pending status and enable bit 0. With enable at 0, a pending interrupt keeps the output low.
- R9: Write status sets bit 0 on a tick-buffer write, bit 1 on an interrupt-count-buffer write and bit 3 on a control write. Writing 1 to a bit clears it, and bit 2 always reads 0.
- R10: While run is 0, both counters hold their values and no interrupt becomes pending.
- R11: After reset, every register reads 0 and every interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, registered |
| tick_irq | output | NUM_CORES (4) | Per-channel interrupt, registered |

## Verification
Assertions check several properties on every cycle. The address decoder selects at most one channel. Each counter stays within its buffer value and freezes when neither stepped nor loaded. A pending status only appears while run and generate are both set, and a one-shot expiry drops the generate bit. A buffer write always shows up in the write-status register. Other behaviours can only be shown by the bench's scenarios: the exact (TB+1)*(IB+1)+1 interrupt latency for several buffer pairs, the recurrence in interval mode, the enable gating, clear-by-writing-1 of the status, and the isolation between channels and from out-of-range addresses.

// File: rtl/tick_array_pkg.sv
package tick_array_pkg;
  // register offsets inside one channel window
  localparam logic [7:0] OFF_TBUF  = 8'h00;
  localparam logic [7:0] OFF_IBUF  = 8'h08;
  localparam logic [7:0] OFF_CTRL  = 8'h20;
  localparam logic [7:0] OFF_STAT  = 8'h30;
  localparam logic [7:0] OFF_IEN   = 8'h34;
  localparam logic [7:0] OFF_WSTAT = 8'h40;
  // control bit positions
  localparam int CTRL_RUN    = 0;
  localparam int CTRL_GEN    = 1;
  localparam int CTRL_RELOAD = 2;
  localparam int CTRL_W      = 3;
  // write-status bit positions
  localparam int WS_TB   = 0;
  localparam int WS_IB   = 1;
  localparam int WS_CTRL = 3;
endpackage

// File: rtl/tick_decode.sv
module tick_decode #(
  parameter int ADDR_W    = 12,
  parameter int NUM_CORES = 4,
  parameter int BASE_PAGE = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_CORES-1:0] hit,
  output logic [7:0]           offset
);
  localparam int PAGE_W = ADDR_W - 8;

  logic [PAGE_W-1:0] page;
  assign page   = addr[ADDR_W-1:8];
  assign offset = addr[7:0];

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_hit
    localparam logic [PAGE_W-1:0] MY_PAGE = PAGE_W'(BASE_PAGE + g);
    assign hit[g] = (page == MY_PAGE);
  end

  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R1
endmodule

// File: rtl/tick_countdown.sv
module tick_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic at_zero;
  assign at_zero = (cnt == '0);
  assign expire  = step && at_zero && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (step) begin
      cnt <= at_zero ? reload_val : cnt - 1'b1;
    end
  end

  AST_CNT_WITHIN_BUF: assert property (@(posedge clk) disable iff (rst)
    cnt <= reload_val); // R3
  AST_CNT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(cnt)); // R10
endmodule

// File: rtl/tick_channel.sv
module tick_channel
  import tick_array_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [7:0]        offset,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [CNT_W-1:0]  tb_q, ib_q, tick_cnt, int_cnt;
  logic [CTRL_W-1:0] ctrl_q;
  logic              pend_q, en_q;
  logic              ws_tb, ws_ib, ws_ctrl;
  logic              tick_exp, int_exp;
  logic              wr_tb, wr_ib, wr_ctrl, wr_stat, wr_ien, wr_ws;

  assign wr_tb   = wr && (offset == OFF_TBUF);
  assign wr_ib   = wr && (offset == OFF_IBUF);
  assign wr_ctrl = wr && (offset == OFF_CTRL);
  assign wr_stat = wr && (offset == OFF_STAT);
  assign wr_ien  = wr && (offset == OFF_IEN);
  assign wr_ws   = wr && (offset == OFF_WSTAT);

  tick_countdown #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst(rst), .load(wr_tb), .load_val(wdata[CNT_W-1:0]),
    .step(ctrl_q[CTRL_RUN]), .reload_val(tb_q), .cnt(tick_cnt),
    .expire(tick_exp));

  tick_countdown #(.CNT_W(CNT_W)) u_int (
    .clk(clk), .rst(rst), .load(wr_ib), .load_val(wdata[CNT_W-1:0]),
    .step(tick_exp && ctrl_q[CTRL_GEN]), .reload_val(ib_q), .cnt(int_cnt),
    .expire(int_exp));

  always_ff @(posedge clk) begin
    if (rst) begin
      tb_q    <= '0;
      ib_q    <= '0;
      ctrl_q  <= '0;
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
      ws_tb   <= 1'b0;
      ws_ib   <= 1'b0;
      ws_ctrl <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (wr_tb) tb_q <= wdata[CNT_W-1:0];
      if (wr_ib) ib_q <= wdata[CNT_W-1:0];
      if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
      else if (int_exp && !ctrl_q[CTRL_RELOAD]) ctrl_q[CTRL_GEN] <= 1'b0;
      if (int_exp) pend_q <= 1'b1;
      else if (wr_stat && wdata[0]) pend_q <= 1'b0;
      if (wr_ien) en_q <= wdata[0];
      if (wr_tb) ws_tb <= 1'b1;
      else if (wr_ws && wdata[WS_TB]) ws_tb <= 1'b0;
      if (wr_ib) ws_ib <= 1'b1;
      else if (wr_ws && wdata[WS_IB]) ws_ib <= 1'b0;
      if (wr_ctrl) ws_ctrl <= 1'b1;
      else if (wr_ws && wdata[WS_CTRL]) ws_ctrl <= 1'b0;
      irq <= pend_q && en_q;
    end
  end

  always_comb begin
    rd_data = '0;
    case (offset)
      OFF_TBUF:  rd_data = DATA_W'(tb_q);
      OFF_IBUF:  rd_data = DATA_W'(ib_q);
      OFF_CTRL:  rd_data = DATA_W'(ctrl_q);
      OFF_STAT:  rd_data = DATA_W'(pend_q);
      OFF_IEN:   rd_data = DATA_W'(en_q);
      OFF_WSTAT: rd_data = DATA_W'({ws_ctrl, 1'b0, ws_ib, ws_tb});
      default:   rd_data = '0;
    endcase
  end

  AST_PEND_NEEDS_RUN_GEN: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(ctrl_q[CTRL_RUN] && ctrl_q[CTRL_GEN])); // R4
  AST_ONESHOT_DROPS_GEN: assert property (@(posedge clk) disable iff (rst)
    ($rose(pend_q) && !$past(ctrl_q[CTRL_RELOAD]) && !$past(wr_ctrl))
      |-> !ctrl_q[CTRL_GEN]); // R6
  AST_TB_WRITE_ACKED: assert property (@(posedge clk) disable iff (rst)
    wr_tb |=> ws_tb); // R9
  AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CTRL_RUN] && !pend_q) |=> !pend_q); // R10
endmodule

// File: rtl/core_tick_array.sv
module core_tick_array #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32,
  parameter int BASE_PAGE = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_CORES-1:0] tick_irq
);
  logic [NUM_CORES-1:0] hit;
  logic [7:0]           offset;
  logic [DATA_W-1:0]    ch_rd [NUM_CORES];
  logic [DATA_W-1:0]    rd_mux;

  tick_decode #(.ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .BASE_PAGE(BASE_PAGE)) u_dec (
    .clk(clk), .rst(rst), .addr(bus_addr), .hit(hit), .offset(offset));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_ch
    tick_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst(rst),
      .wr(bus_sel && bus_wr && hit[g]),
      .offset(offset), .wdata(bus_wdata),
      .rd_data(ch_rd[g]), .irq(tick_irq[g]));
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CORES; i++)
      if (hit[i]) rd_mux = rd_mux | ch_rd[i];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
  end
endmodule

// File: tb/test_core_tick_array.sv
module test_core_tick_array;
  localparam int NC = 4;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] tick_irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  core_tick_array #(.NUM_CORES(NC)) i_core_tick_array (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_irq(tick_irq));

  // {channel, tick buffer, interrupt-count buffer}
  localparam int VEC [0:3][0:2] = '{'{0, 3, 1}, '{1, 0, 0}, '{2, 5, 2}, '{3, 1, 4}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [11:0] base(input int ch);
    return 12'h300 + 12'(ch) * 12'h100;
  endfunction

  task automatic wait_irq(input int ch, input int lim, output int n);
    n = 0;
    for (int k = 0; k < lim; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (tick_irq[ch]) return;
    end
    n = -1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R11 reset state
    chk("R11 irq", 32'(tick_irq), 0);
    foreach (VEC[i]) begin
      rd(base(i) + 12'h00, d); chk("R11 tbuf", d, 0);
      rd(base(i) + 12'h20, d); chk("R11 ctrl", d, 0);
    end
    rd(base(0) + 12'h30, d); chk("R11 stat", d, 0);
    rd(base(0) + 12'h40, d); chk("R11 wstat", d, 0);

    // R2 / R9 readback and write status
    wr(base(0) + 12'h00, 32'h1234_5678);
    rd(base(0) + 12'h00, d); chk("R2 tbuf readback", d, 32'h1234_5678);
    rd(base(0) + 12'h40, d); chk("R9 wstat after tbuf", d, 32'h1);
    wr(base(0) + 12'h08, 32'hA5);
    rd(base(0) + 12'h08, d); chk("R2 ibuf readback", d, 32'hA5);
    wr(base(0) + 12'h20, 32'h0);
    rd(base(0) + 12'h40, d); chk("R9 wstat three bits", d, 32'hB);
    wr(base(0) + 12'h40, 32'h2);
    rd(base(0) + 12'h40, d); chk("R9 w1c bit1", d, 32'h9);
    wr(base(0) + 12'h40, 32'hF);
    rd(base(0) + 12'h40, d); chk("R9 w1c all", d, 32'h0);
    rd(base(0) + 12'h10, d); chk("R2 unmapped offset", d, 32'h0);

    // R1 isolation and out-of-range
    rd(base(1) + 12'h00, d); chk("R1 other channel untouched", d, 32'h0);
    wr(12'h200, 32'hDEAD_BEEF);
    rd(base(0) + 12'h00, d); chk("R1 low address ignored", d, 32'h1234_5678);
    rd(12'h200, d); chk("R1 low address reads 0", d, 32'h0);
    wr(12'h700, 32'hCAFE);
    rd(12'h700, d); chk("R1 high address reads 0", d, 32'h0);
    rd(base(3) + 12'h00, d); chk("R1 ch3 untouched", d, 32'h0);

    // R3 / R4 latency vectors
    foreach (VEC[i]) begin
      int ch, tb, ib;
      ch = VEC[i][0]; tb = VEC[i][1]; ib = VEC[i][2];
      wr(base(ch) + 12'h00, 32'(tb));
      wr(base(ch) + 12'h08, 32'(ib));
      wr(base(ch) + 12'h34, 32'h1);
      wr(base(ch) + 12'h20, 32'h7);
      wait_irq(ch, 500, n);
      chk("R4 R3 irq latency", 32'(n), 32'((tb + 1) * (ib + 1) + 1));
      wr(base(ch) + 12'h20, 32'h0);
      wr(base(ch) + 12'h30, 32'h1);
      wr(base(ch) + 12'h40, 32'hB);
      @(negedge clk);
      chk("R7 irq cleared", 32'(tick_irq[ch]), 0);
    end

    // R8 enable gating, R6 one-shot, R7 clear
    wr(base(0) + 12'h34, 32'h0);
    wr(base(0) + 12'h00, 32'h1);
    wr(base(0) + 12'h08, 32'h0);
    wr(base(0) + 12'h20, 32'h3);
    repeat (10) @(negedge clk);
    chk("R8 gated irq low", 32'(tick_irq[0]), 0);
    rd(base(0) + 12'h30, d); chk("R7 pending set", d, 32'h1);
    rd(base(0) + 12'h20, d); chk("R6 gen bit cleared", d, 32'h1);
    wr(base(0) + 12'h34, 32'h1);
    @(negedge clk);
    chk("R8 irq after enable", 32'(tick_irq[0]), 1);
    wr(base(0) + 12'h30, 32'h1);
    @(negedge clk);
    chk("R7 irq after w1c", 32'(tick_irq[0]), 0);
    repeat (50) @(negedge clk);
    rd(base(0) + 12'h30, d); chk("R6 no further pending", d, 32'h0);

    // R5 interval recurrence
    wr(base(0) + 12'h20, 32'h7);
    wait_irq(0, 20, n);
    chk("R5 first interval irq", 32'(n > 0), 1);
    wr(base(0) + 12'h30, 32'h1);
    wait_irq(0, 20, n);
    chk("R5 recurring irq", 32'(n > 0), 1);
    rd(base(0) + 12'h20, d); chk("R5 ctrl kept", d, 32'h7);

    // R10 stop
    wr(base(0) + 12'h20, 32'h0);
    wr(base(0) + 12'h30, 32'h1);
    repeat (50) @(negedge clk);
    chk("R10 stopped irq", 32'(tick_irq[0]), 0);
    rd(base(0) + 12'h30, d); chk("R10 stopped stat", d, 32'h0);
    wr(base(0) + 12'h20, 32'h1);
    repeat (50) @(negedge clk);
    rd(base(0) + 12'h30, d); chk("R4 run without gen stays idle", d, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule